// File: doc/BRIEF.md
# Register-Triggered I2C Transaction Engine

This block is an I2C master that carries out one complete SMBus-style transfer by itself after software sets a single start bit. Software first sets up the transfer. It writes the target's 7-bit address, a register-address prefix of zero to three bytes, a payload length of one to sixteen bytes, the transfer direction and the bus speed. It also fills up to four 32-bit payload words for a write. It then sets the start bit and polls it. The bit drops when the STOP condition has been sent.

The engine drives the START condition, the address byte, the register-address bytes and the payload, and checks the acknowledge after every byte it sends. For a read that has a register-address prefix, it writes the prefix and then issues a repeated START with the read bit set. Received bytes are packed into the payload words with the least significant byte first. If the target fails to acknowledge, a sticky error bit is set and the transfer ends with a STOP.

The pins are open-drain: an enable output pulls the line low. A 3-bit field chooses which of eight SDA pins the surrounding pin mux routes to. SCL comes only from the internal divider, and the target cannot stretch it.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset all registers read as zero, the start bit is clear, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: Word 0 (byte offset 0x00) holds the fields below. Bit 7 reads 0, and the error bit cannot be written by software.
  - bits 31:8: register address
  - bits 6:4: SDA pin select
  - bit 3: SCL drive enable
  - bit 2: direction (1 = write)
  - bit 1: error
  - bit 0: start
- R3: Word 1 (offset 0x04) holds the fields below, and bits 31:16 read 0.
  - bit 15: read-mode flag (stored only)
  - bits 14:8: target address
  - bits 7:4: length minus one
  - bits 3:2: prefix width in bytes
  - bits 1:0: speed
- R4: A write sends the following, then clears the start bit:
  - START
  - target address with R/W = 0
  - the prefix bytes, taken from bits 31:8 of word 0, most significant byte first
  - the payload bytes in increasing index order
  - STOP
- R5: A read with a non-zero prefix width sends the following:
  - START
  - target address with R/W = 0
  - the prefix bytes
  - a repeated START
  - target address with R/W = 1
  - then it receives the payload
- R6: A read with prefix width 0 sends START and the target address with R/W = 1, then receives the payload at once.
- R7: During a read the engine ACKs every received byte except the last, which gets a NACK, and then sends STOP.
- R8: Payload byte i sits in data word i/4 (offsets 0x08, 0x0C, 0x10, 0x14) at bits 8*(i mod 4)+7 down to 8*(i mod 4), for both directions. A read changes only the bytes it receives.
- R9: A NACK on any byte the engine sends sets the error bit, ends the transfer with STOP and clears the start bit. The error bit stays readable until the next start, which clears it.
- R10: With speed = 1 the SCL period is CLK_HZ/400000 clock cycles; with any other speed value it is CLK_HZ/100000. SCL high time is half the period, and SCL depends on nothing outside the block.
- R11: Apart from START and STOP, the engine changes `sda_oe` only while it holds SCL low.
- R12: While a transfer runs, bus writes to any register are ignored, including a second start.
- R13: `sda_sel` reflects bits 6:4 of word 0, and `scl_oe` is never asserted while bit 3 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed level of the selected SDA pin |
| sda_sel | output | 3 | SDA pin select for the external mux |

## Verification
A behavioural target model on the wire decodes START, STOP, bytes and acknowledges into an event list. Each transfer is then compared against an event list the bench builds from the configured fields. The transfers tried are:
- a fast write with a two-byte prefix and five payload bytes, which checks prefix order and byte packing across a word boundary
- a one-byte-prefix read, which separates the repeated-start path from the direct read and shows that unreceived bytes keep their value
- a sixteen-byte direct read, which fills all four words and checks the final NACK
- a standard-speed write with a three-byte prefix, which measures SCL period and duty and carries bus writes issued mid-transfer
- a wrong-address transfer and one with SCL drive disabled, which cover the error path and the pin controls

// File: rtl/i2c_seq_master.sv
module i2c_seq_master #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_i,
  output logic [2:0]  sda_sel
);

  localparam int QSTD_RAW  = CLK_HZ / 400_000;
  localparam int QFAST_RAW = CLK_HZ / 1_600_000;
  localparam int QSTD  = (QSTD_RAW  < 1) ? 1 : QSTD_RAW;
  localparam int QFAST = (QFAST_RAW < 1) ? 1 : QFAST_RAW;
  localparam int CW    = $clog2(QSTD + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;
  typedef enum logic [2:0] {K_ADDR, K_REG, K_RADDR, K_WDATA, K_RDATA} kind_t;

  st_t         st;
  kind_t       kind;
  logic [23:0] mem_addr;
  logic [2:0]  pin_sel;
  logic        scl_en, dir_wr, fail, trig;
  logic        rd_mode;
  logic [6:0]  dev;
  logic [3:0]  lenm1;
  logic [1:0]  regw, speed;
  logic [31:0] dw [4];

  logic [CW-1:0] qcnt, qlim;
  logic [1:0]    q;
  logic [3:0]    bitn, idx;
  logic [1:0]    ridx;
  logic [7:0]    sh;
  logic          samp, sda_drv;
  logic          tick, is_tx, bit_low, scl_low;

  function automatic logic [7:0] fetch(input logic [3:0] i);
    return dw[i[3:2]][{i[1:0], 3'b000} +: 8];
  endfunction

  function automatic logic [7:0] mbyte(input logic [1:0] k);
    return mem_addr[{k, 3'b000} +: 8];
  endfunction

  assign qlim    = (speed == 2'd1) ? CW'(QFAST) : CW'(QSTD);
  assign tick    = (qcnt == qlim - 1'b1);
  assign is_tx   = (kind != K_RDATA);
  assign bit_low = (bitn != 4'd8) ? (is_tx && !sh[7]) : (!is_tx && idx != lenm1);
  assign scl_low = (st != S_IDLE) && !q[1];
  assign scl_oe  = scl_en && scl_low;
  assign sda_oe  = sda_drv;
  assign sda_sel = pin_sel;

  always_comb begin
    case (bus_addr[4:2])
      3'd0:    bus_rdata = {mem_addr, 1'b0, pin_sel, scl_en, dir_wr, fail, trig};
      3'd1:    bus_rdata = {16'h0, rd_mode, dev, lenm1, regw, speed};
      3'd2:    bus_rdata = dw[0];
      3'd3:    bus_rdata = dw[1];
      3'd4:    bus_rdata = dw[2];
      3'd5:    bus_rdata = dw[3];
      default: bus_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR;
      mem_addr <= '0; pin_sel <= '0; scl_en <= 1'b0; dir_wr <= 1'b0;
      fail <= 1'b0; trig <= 1'b0; rd_mode <= 1'b0; dev <= '0;
      lenm1 <= '0; regw <= '0; speed <= '0;
      for (int i = 0; i < 4; i++) dw[i] <= '0;
      qcnt <= '0; q <= '0; bitn <= '0; idx <= '0; ridx <= '0;
      sh <= '0; samp <= 1'b1; sda_drv <= 1'b0;
    end else if (st == S_IDLE) begin
      qcnt <= '0;
      q    <= '0;
      if (bus_we) begin
        case (bus_addr[4:2])
          3'd0: begin
            mem_addr <= bus_wdata[31:8];
            pin_sel  <= bus_wdata[6:4];
            scl_en   <= bus_wdata[3];
            dir_wr   <= bus_wdata[2];
            if (bus_wdata[0]) begin
              trig <= 1'b1;
              fail <= 1'b0;
              st   <= S_START;
              kind <= K_ADDR;
              idx  <= '0;
              bitn <= '0;
              sh   <= {dev, !bus_wdata[2] && regw == 2'd0};
            end
          end
          3'd1: begin
            rd_mode <= bus_wdata[15];
            dev     <= bus_wdata[14:8];
            lenm1   <= bus_wdata[7:4];
            regw    <= bus_wdata[3:2];
            speed   <= bus_wdata[1:0];
          end
          3'd2: dw[0] <= bus_wdata;
          3'd3: dw[1] <= bus_wdata;
          3'd4: dw[2] <= bus_wdata;
          3'd5: dw[3] <= bus_wdata;
          default: ;
        endcase
      end
    end else if (!tick) begin
      qcnt <= qcnt + 1'b1;
    end else begin
      qcnt <= '0;
      q    <= q + 1'b1;
      if (q == 2'd0) begin
        case (st)
          S_START: sda_drv <= 1'b0;
          S_STOP:  sda_drv <= 1'b1;
          S_BIT:   sda_drv <= bit_low;
          default: ;
        endcase
      end
      if (q == 2'd2) begin
        samp <= sda_i;
        if (st == S_START) sda_drv <= 1'b1;
        if (st == S_STOP)  sda_drv <= 1'b0;
      end
      if (q == 2'd3) begin
        case (st)
          S_START: begin
            st   <= S_BIT;
            bitn <= '0;
          end
          S_STOP: begin
            st   <= S_IDLE;
            trig <= 1'b0;
          end
          S_BIT: begin
            if (bitn != 4'd8) begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[6:0], samp};
            end else begin
              bitn <= '0;
              if (is_tx && samp) begin
                fail <= 1'b1;
                st   <= S_STOP;
              end else begin
                case (kind)
                  K_ADDR: begin
                    if (regw != 2'd0) begin
                      kind <= K_REG;
                      ridx <= regw - 1'b1;
                      sh   <= mbyte(regw - 1'b1);
                    end else if (dir_wr) begin
                      kind <= K_WDATA;
                      idx  <= '0;
                      sh   <= fetch(4'd0);
                    end else begin
                      kind <= K_RDATA;
                      idx  <= '0;
                    end
                  end
                  K_REG: begin
                    if (ridx != 2'd0) begin
                      ridx <= ridx - 1'b1;
                      sh   <= mbyte(ridx - 1'b1);
                    end else if (dir_wr) begin
                      kind <= K_WDATA;
                      idx  <= '0;
                      sh   <= fetch(4'd0);
                    end else begin
                      kind <= K_RADDR;
                      sh   <= {dev, 1'b1};
                      st   <= S_START;
                    end
                  end
                  K_RADDR: begin
                    kind <= K_RDATA;
                    idx  <= '0;
                  end
                  K_WDATA: begin
                    if (idx == lenm1) st <= S_STOP;
                    else begin
                      idx <= idx + 1'b1;
                      sh  <= fetch(idx + 1'b1);
                    end
                  end
                  default: begin
                    dw[idx[3:2]][{idx[1:0], 3'b000} +: 8] <= sh;
                    if (idx == lenm1) st <= S_STOP;
                    else idx <= idx + 1'b1;
                  end
                endcase
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_TRIG_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    trig == (st != S_IDLE)); // R4

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_oe && !sda_oe)); // R1

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && !$stable(sda_oe)) |-> (scl_low && $past(scl_low))); // R11

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> ($stable(dev) && $stable(lenm1) && $stable(mem_addr) && $stable(regw))); // R12

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (idx <= lenm1)); // R8

  AST_FAIL_CLEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> !fail); // R9

endmodule

// File: tb/sim_i2c_seq_master.sv
module sim_i2c_seq_master;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ = 8_000_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic scl_oe, sda_oe, sda_i;
  logic [2:0] sda_sel;

  int checks = 0, failures = 0;

  logic s_pull = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_pull);
  assign sda_i = sda_line;

  always #(CLK_PERIOD/2) clk = !clk;

  i2c_seq_master #(.CLK_HZ(SYS_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_i(sda_i), .sda_sel(sda_sel));

  // behavioural target: 1000=START 1001=STOP 1100=master ACK 1101=master NACK, else byte sent by master
  int log_q[$];
  int exp_q[$];
  logic scl_prev = 1'b1, sda_prev = 1'b1;
  logic [7:0] t_sh = '0;
  int t_cnt = 0, t_mode = 0, t_k = 0;
  logic t_first = 1'b0, t_ack = 1'b0, t_rw = 1'b0;
  logic [6:0] t_addr = 7'h50;

  int cyc = 0, last_rise = -1, per = 0, hi = 0;
  logic saw_scl = 1'b0;

  always @(negedge clk) begin
    logic [7:0] tb_byte;
    cyc++;
    if (scl_oe) saw_scl = 1'b1;
    if (scl_line && scl_prev && sda_prev && !sda_line) begin
      log_q.push_back(1000);
      t_cnt = 0; t_mode = 1; t_first = 1'b1; s_pull = 1'b0;
    end else if (scl_line && scl_prev && !sda_prev && sda_line) begin
      log_q.push_back(1001);
      t_mode = 0; s_pull = 1'b0;
    end else if (scl_line && !scl_prev) begin
      if (last_rise >= 0) per = cyc - last_rise;
      last_rise = cyc;
      if (t_mode == 1) begin
        if (t_cnt < 8) t_sh = {t_sh[6:0], sda_line};
        t_cnt++;
        if (t_cnt == 8) begin
          log_q.push_back(int'(t_sh));
          t_ack = t_first ? (t_sh[7:1] == t_addr) : 1'b1;
          if (t_first) t_rw = t_sh[0];
        end
        if (t_cnt == 9) begin
          t_cnt = 0;
          if (t_first) begin
            t_first = 1'b0;
            if (t_ack && t_rw) begin t_mode = 2; t_k = 0; end
          end
        end
      end else if (t_mode == 2) begin
        t_cnt++;
        if (t_cnt == 9) begin
          log_q.push_back(sda_line ? 1101 : 1100);
          t_cnt = 0; t_k++;
          if (sda_line) t_mode = 0;
        end
      end
    end else if (!scl_line && scl_prev) begin
      hi = cyc - last_rise;
      tb_byte = 8'hA0 + 8'(t_k);
      if (t_mode == 1) s_pull = (t_cnt == 8) && t_ack;
      else if (t_mode == 2) s_pull = (t_cnt < 8) && !tb_byte[7 - t_cnt];
      else s_pull = 1'b0;
    end
    scl_prev = scl_line;
    sda_prev = sda_line;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    v = 32'h1;
    while (v[0] && n < 40000) begin
      rd(5'h00, v);
      n++;
    end
    if (v[0]) check(1'b0, {tag, " timeout"}, n, 40000);
  endtask

  task automatic cmp_log(input string tag);
    int bad;
    bad = -1;
    if (log_q.size() == exp_q.size()) begin
      foreach (exp_q[i]) if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
      if (bad < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, {tag, " event"}, log_q[bad], exp_q[bad]);
    end else check(1'b0, {tag, " event count"}, log_q.size(), exp_q.size());
    log_q.delete();
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'h00, v); check(v == 32'h0, "R1 word0 reset", v, 0);
    rd(5'h04, v); check(v == 32'h0, "R1 word1 reset", v, 0);
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    // R2 R3 read back, no start
    wr(5'h04, 32'h0000D5ED);
    rd(5'h04, v); check(v == 32'h0000D5ED, "R3 word1 readback", v, 32'hD5ED);
    wr(5'h00, 32'h123456FA);
    rd(5'h00, v); check(v == 32'h12345678, "R2 word0 readback", v, 32'h12345678);
    check(sda_sel == 3'd7, "R13 sda_sel", sda_sel, 7);
    log_q.delete();

    // R4 R8 fast write, two prefix bytes, five payload bytes
    wr(5'h08, 32'h44332211);
    wr(5'h0C, 32'h00000055);
    wr(5'h04, 32'h00005049);
    wr(5'h00, 32'hAB12340D);
    wait_done("R4");
    exp_q = '{1000, 'hA0, 'h12, 'h34, 'h11, 'h22, 'h33, 'h44, 'h55, 1001};
    cmp_log("R4 R8 write sequence");
    rd(5'h00, v); check(v[1:0] == 2'b00, "R4 start cleared no error", v[1:0], 0);

    // R5 R7 R8 read with one prefix byte, three bytes
    wr(5'h04, 32'h00005025);
    wr(5'h00, 32'h00000709);
    wait_done("R5");
    exp_q = '{1000, 'hA0, 'h07, 1000, 'hA1, 1100, 1100, 1101, 1001};
    cmp_log("R5 R7 repeated start read");
    rd(5'h08, v); check(v == 32'h44A2A1A0, "R8 partial word", v, 32'h44A2A1A0);

    // R6 R7 R8 direct read of sixteen bytes
    wr(5'h04, 32'h000050F1);
    wr(5'h00, 32'h00000009);
    wait_done("R6");
    exp_q = '{1000, 'hA1};
    for (int i = 0; i < 15; i++) exp_q.push_back(1100);
    exp_q.push_back(1101);
    exp_q.push_back(1001);
    cmp_log("R6 R7 direct read");
    for (int w = 0; w < 4; w++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[8*b +: 8] = 8'hA0 + 8'(4*w + b);
      rd(5'(8 + 4*w), v);
      check(v == e, "R8 packed word", v, e);
    end

    // R9 NACK on address
    wr(5'h04, 32'h00003305);
    wr(5'h00, 32'h0000010D);
    wait_done("R9");
    exp_q = '{1000, 'h66, 1001};
    cmp_log("R9 abort sequence");
    rd(5'h00, v); check(v[1:0] == 2'b10, "R9 error sticky start clear", v[1:0], 2);

    // R10 R12 standard speed write, three prefix bytes, writes while busy
    wr(5'h08, 32'h0000005A);
    wr(5'h04, 32'h0000500C);
    wr(5'h00, 32'hC0FFEE0D);
    rd(5'h00, v); check(v[1:0] == 2'b01, "R9 error cleared by start", v[1:0], 1);
    repeat (100) @(negedge clk);
    wr(5'h04, 32'h00003301);
    wr(5'h08, 32'hFFFFFFFF);
    wr(5'h00, 32'h1111110D);
    wait_done("R10");
    exp_q = '{1000, 'hA0, 'hC0, 'hFF, 'hEE, 'h5A, 1001};
    cmp_log("R12 busy writes ignored");
    rd(5'h04, v); check(v == 32'h0000500C, "R12 word1 unchanged", v, 32'h500C);
    rd(5'h08, v); check(v == 32'h0000005A, "R12 data word unchanged", v, 32'h5A);
    check(per == SYS_HZ / 100_000, "R10 standard period", per, SYS_HZ / 100_000);
    check(hi == SYS_HZ / 200_000, "R10 standard high time", hi, SYS_HZ / 200_000);

    // R10 fast period, R13 SCL drive disabled
    wr(5'h04, 32'h00005001);
    wr(5'h00, 32'h0000000D);
    wait_done("R10f");
    check(per == SYS_HZ / 400_000, "R10 fast period", per, SYS_HZ / 400_000);
    log_q.delete();
    saw_scl = 1'b0;
    wr(5'h00, 32'h00000055);
    wait_done("R13");
    check(!saw_scl, "R13 scl never driven", saw_scl, 0);
    check(sda_sel == 3'd5, "R13 pin select", sda_sel, 5);
    rd(5'h00, v); check(v[1:0] == 2'b10, "R9 R13 unclocked NACK", v[1:0], 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule